// File: doc/BRIEF.md
# Asynchronous Transmit FIFO Write Controller

This block is the host-facing write side of the FIFO that holds asynchronous packets waiting for transmission on a serial bus. The host writes 8-bit or 16-bit parts over a microcontroller-style bus. The block collects the parts into 32-bit quadlets and tags each quadlet with a start-of-packet bit. It stores the tagged quadlets and releases a packet to the transmitter only once the host has confirmed it.

Packet framing comes from the write address. The window at 50h to 5Fh is split into four quadlet slots. The slot at 50h starts a packet. The slot at 54h appends without confirming. The slot at 58h appends and confirms. The slot at 5Ch takes a whole packet in one burst.

Misuse and underflow put the block into a sticky stuck state. In that state nothing asynchronous is released until software sets the FIFO-clear bit. Isochronous scheduling is not affected by the stuck state.

Top module: `atx_wr_ctrl`

## Requirements
- R1: `bus_ack_n` equals the value `bus_sel_n` had one clock earlier, so a held select gives an acknowledge that is low one cycle later. It returns to 1 at reset.
- R2: With `bus_narrow`=1, each write carries one byte on `bus_wdata[7:0]`. The four bytes of a quadlet are taken most significant first. The quadlet is stored only after the fourth byte.
- R3: With `bus_narrow`=0, each write carries 16 bits. The first write forms quadlet bits 31:16 and the second forms bits 15:0. The quadlet is stored after the second write.
- R4: A quadlet written to slot 50h is stored with `tx_first`=1. Quadlets written to slots 54h and 58h are stored with `tx_first`=0.
- R5: Quadlets written to 50h or 54h stay unconfirmed, and `tx_avail` stays 0. A quadlet completed at 58h confirms every stored quadlet, `tx_avail` rises, and the packet pops out in write order.
- R6: A packet whose first quadlet arrives at 54h or 58h (when no packet is open) sets `stuck_irq`.
- R7: A `tx_pop` while no confirmed quadlet is held is an underflow and sets `stuck_irq`.
- R8: While `stuck_irq`=1, `tx_avail` is 0, pops are ignored and window writes are dropped. The state persists until a write of 1 to bit 0 at address 30h.
- R9: That clear write empties the storage, discards a partly assembled quadlet and clears `stuck_irq` and `overflow`.
- R10: While select is held low on slot 5Ch, one 16-bit word is taken per clock. Only the first quadlet of the burst gets `tx_first`=1. The packet is confirmed in the cycle select rises.
- R11: A quadlet completed while DEPTH quadlets are stored is dropped, and the sticky `overflow` flag is set.
- R12: `iso_go` follows `iso_req` whatever the stuck state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | active-low reset |
| bus_sel_n | input | 1 | chip select, active low |
| bus_we | input | 1 | 1 marks a write access |
| bus_addr | input | 6 | address bits 7:2; part order is kept internally |
| bus_wdata | input | 16 | write data |
| bus_narrow | input | 1 | 1 = 8-bit writes, 0 = 16-bit writes |
| bus_ack_n | output | 1 | acknowledge, select delayed one cycle |
| tx_pop | input | 1 | transmitter consumes the head quadlet |
| tx_data | output | 32 | head quadlet |
| tx_first | output | 1 | head quadlet starts a packet |
| tx_avail | output | 1 | a confirmed quadlet is at the head |
| stuck_irq | output | 1 | stuck state / interrupt |
| overflow | output | 1 | sticky dropped-write flag |
| iso_req | input | 1 | isochronous request |
| iso_go | output | 1 | isochronous grant |

## Verification
The bench builds the block with DEPTH=4. With that depth, a five-quadlet packet reaches the full condition and the dropped-write path after a handful of writes. A three-quadlet burst and a three-quadlet packet still fit without wrapping concerns. Pointer wrap-around is reached because later tests reuse the storage after clears and pops.

// File: rtl/atx_wr_ctrl.sv
module atx_wr_ctrl #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel_n,
  input  logic        bus_we,
  input  logic [7:2]  bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        bus_narrow,
  output logic        bus_ack_n,
  input  logic        tx_pop,
  output logic [31:0] tx_data,
  output logic        tx_first,
  output logic        tx_avail,
  output logic        stuck_irq,
  output logic        overflow,
  input  logic        iso_req,
  output logic        iso_go
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [32:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] used, conf, used_n;
  logic [1:0]    part;
  logic [31:0]   asm_q;
  logic          in_pkt, bst;

  wire        hit_win  = !bus_sel_n && bus_we && bus_addr[7:4] == 4'h5;
  wire        hit_clr  = !bus_sel_n && bus_we && bus_addr == 6'h0C && bus_wdata[0];
  wire [1:0]  rgn      = bus_addr[3:2];
  wire        lastp    = bus_narrow ? (part == 2'd3) : (part == 2'd1);
  wire        qdone    = hit_win && !stuck_irq && lastp;
  wire [31:0] quad     = bus_narrow ? {asm_q[23:0], bus_wdata[7:0]} : {asm_q[15:0], bus_wdata};
  wire        tag      = (rgn == 2'd0) || (rgn == 2'd3 && !bst);
  wire        orphan   = qdone && !tag && !in_pkt;
  wire        full     = used == CW'(DEPTH);
  wire        push     = qdone && !orphan && !full;
  wire        pop_ok   = tx_pop && conf != '0 && !stuck_irq;
  wire        under    = tx_pop && conf == '0 && !stuck_irq;
  wire        burst_end = bst && bus_sel_n;
  wire        confirm  = (qdone && !orphan && rgn == 2'd2) || burst_end;

  assign used_n   = used + CW'(push) - CW'(pop_ok);
  assign tx_data  = mem[rptr][31:0];
  assign tx_first = mem[rptr][32];
  assign tx_avail = conf != '0 && !stuck_irq;
  assign iso_go   = iso_req;

  always_ff @(posedge clk)
    if (push) mem[wptr] <= {tag, quad};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack_n <= 1'b1;
      part <= '0; asm_q <= '0; wptr <= '0; rptr <= '0; used <= '0; conf <= '0;
      stuck_irq <= 1'b0; overflow <= 1'b0; in_pkt <= 1'b0; bst <= 1'b0;
    end else begin
      bus_ack_n <= bus_sel_n;
      if (hit_clr) begin
        part <= '0; asm_q <= '0; wptr <= '0; rptr <= '0; used <= '0; conf <= '0;
        stuck_irq <= 1'b0; overflow <= 1'b0; in_pkt <= 1'b0; bst <= 1'b0;
      end else begin
        if (hit_win && !stuck_irq) begin
          part  <= lastp ? 2'd0 : part + 2'd1;
          asm_q <= quad;
        end
        if (push)   wptr <= wptr + 1'b1;
        if (pop_ok) rptr <= rptr + 1'b1;
        used <= used_n;
        conf <= confirm ? used_n : conf - CW'(pop_ok);
        if (orphan || under) stuck_irq <= 1'b1;
        if (qdone && !orphan && full) overflow <= 1'b1;
        if (confirm) in_pkt <= 1'b0;
        else if (push && tag) in_pkt <= 1'b1;
        if (burst_end) bst <= 1'b0;
        else if (qdone && !orphan && rgn == 2'd3) bst <= 1'b1;
      end
    end
  end

  p_ack_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel_n |=> !bus_ack_n);
  p_conf_le_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conf <= used);
  p_orphan_stuck_r6: assert property (@(posedge clk) disable iff (!rst_n)
    orphan && !hit_clr |=> stuck_irq);
  p_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    under && !hit_clr |=> stuck_irq && $stable(rptr));
  p_stuck_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_irq && !hit_clr |=> stuck_irq);
  p_stuck_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_irq |-> !tx_avail);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> used == '0 && !stuck_irq && !overflow);
  p_no_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CW'(DEPTH));
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !hit_clr |=> overflow);
endmodule

// File: tb/tb_atx_wr_ctrl.sv
module tb_atx_wr_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_sel_n = 1, bus_we = 0, bus_narrow = 0, tx_pop = 0, iso_req = 0;
  logic [7:2] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic bus_ack_n, tx_first, tx_avail, stuck_irq, overflow, iso_go;
  logic [31:0] tx_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  atx_wr_ctrl #(.DEPTH(4)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [15:0] d, logic nar);
    @(negedge clk);
    bus_sel_n = 0; bus_we = 1; bus_addr = a[7:2]; bus_wdata = d; bus_narrow = nar;
    @(negedge clk);
    bus_sel_n = 1; bus_we = 0;
  endtask

  task automatic wq(logic [7:0] a, logic [31:0] q);
    bus_wr(a, q[31:16], 0);
    bus_wr(a + 8'd2, q[15:0], 0);
  endtask

  task automatic clr();
    bus_wr(8'h30, 16'h0001, 0);
  endtask

  task automatic pop1();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic head(string req, logic [31:0] d, logic f);
    chk(req, tx_data, d);
    chk(req, tx_first, f);
    pop1();
  endtask

  task automatic t_reset();
    chk("R1 reset ack", bus_ack_n, 1);
    chk("R5 reset avail", tx_avail, 0);
    chk("R8 reset stuck", stuck_irq, 0);
    chk("R11 reset ovf", overflow, 0);
  endtask

  task automatic t_word_pkt();
    wq(8'h50, 32'hA1B2C3D4);
    chk("R5 first unconfirmed", tx_avail, 0);
    wq(8'h54, 32'h11223344);
    chk("R5 continue unconfirmed", tx_avail, 0);
    wq(8'h58, 32'h55667788);
    chk("R5 confirmed", tx_avail, 1);
    head("R3 R4 word q0", 32'hA1B2C3D4, 1);
    head("R4 word q1", 32'h11223344, 0);
    head("R4 word q2", 32'h55667788, 0);
    chk("R5 drained", tx_avail, 0);
  endtask

  task automatic t_byte_pkt();
    bus_wr(8'h50, 16'h00DE, 1); bus_wr(8'h51, 16'h00AD, 1); bus_wr(8'h52, 16'h00BE, 1);
    bus_wr(8'h53, 16'h00EF, 1);
    bus_wr(8'h58, 16'h0001, 1); bus_wr(8'h59, 16'h0002, 1); bus_wr(8'h5A, 16'h0003, 1);
    chk("R2 three bytes not stored", tx_avail, 0);
    bus_wr(8'h5B, 16'h0004, 1);
    chk("R2 avail after fourth", tx_avail, 1);
    head("R2 byte q0", 32'hDEADBEEF, 1);
    head("R2 byte q1", 32'h01020304, 0);
  endtask

  task automatic t_orphan();
    wq(8'h54, 32'hCAFEF00D);
    chk("R6 orphan stuck", stuck_irq, 1);
    wq(8'h50, 32'h0BADBEEF);
    wq(8'h58, 32'h12121212);
    chk("R8 no release while stuck", tx_avail, 0);
    chk("R8 stays stuck", stuck_irq, 1);
    iso_req = 1; #1;
    chk("R12 iso while stuck", iso_go, 1);
    iso_req = 0; #1;
    chk("R12 iso low", iso_go, 0);
    clr();
    chk("R8 cleared", stuck_irq, 0);
    chk("R8 dropped writes left nothing", tx_avail, 0);
  endtask

  task automatic t_underflow();
    pop1();
    chk("R7 underflow stuck", stuck_irq, 1);
    clr();
    chk("R9 clear after underflow", stuck_irq, 0);
  endtask

  task automatic t_burst();
    logic [15:0] w [6] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 1) chk("R1 ack low after one cycle", bus_ack_n, 0);
      if (i == 5) chk("R10 unconfirmed mid burst", tx_avail, 0);
      bus_sel_n = 0; bus_we = 1; bus_addr = 6'h17; bus_wdata = w[i]; bus_narrow = 0;
    end
    @(negedge clk);
    bus_sel_n = 1; bus_we = 0;
    @(negedge clk);
    chk("R1 ack high after select", bus_ack_n, 1);
    chk("R10 confirmed at end", tx_avail, 1);
    head("R10 burst q0", 32'h11112222, 1);
    head("R10 burst q1", 32'h33334444, 0);
    head("R10 burst q2", 32'h55556666, 0);
    chk("R10 drained", tx_avail, 0);
  endtask

  task automatic t_clear_partial();
    bus_wr(8'h50, 16'h00FF, 1);
    clr();
    wq(8'h50, 32'h12345678);
    wq(8'h58, 32'h9ABCDEF0);
    head("R9 assembler reset q0", 32'h12345678, 1);
    head("R9 assembler reset q1", 32'h9ABCDEF0, 0);
  endtask

  task automatic t_overflow();
    wq(8'h50, 32'h00000001);
    for (int i = 0; i < 3; i++) wq(8'h54, 32'h00000010 + i);
    chk("R11 full no ovf yet", overflow, 0);
    wq(8'h54, 32'hDEAD0000);
    chk("R11 ovf set", overflow, 1);
    wq(8'h58, 32'hDEAD0001);
    chk("R11 ovf sticky", overflow, 1);
    chk("R11 stored four confirmed", tx_avail, 1);
    chk("R11 head intact", tx_data, 32'h00000001);
    clr();
    chk("R9 clear ovf", overflow, 0);
    chk("R9 clear empties", tx_avail, 0);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_word_pkt();
    t_byte_pkt();
    t_orphan();
    t_underflow();
    t_burst();
    t_clear_partial();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule